// File: doc/BRIEF.md
# Pipelined Sorting-Network Permutation Router

This block takes eight data words together with eight destination lane numbers and delivers each word to the output lane it names. The words arrive in parallel, one from each memory bank, and leave in parallel, one to each decoder lane. The eight lane numbers must be all different, so that they form a permutation and every output lane receives exactly one word.

The routing control is worked out on the fly. A steering network of compare-exchange cells sorts the lane numbers into ascending order, and every cell records whether it swapped its pair. A follower network with the same wiring applies those recorded decisions to the data words one column later. Registers sit between the columns, so the router accepts a new permutation in every cycle and delivers it nine cycles later. No switch settings are stored anywhere.

Top module: `pw_perm_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0 and out_data is all zeros.
- R2: out_valid repeats in_valid delayed by exactly 9 clock cycles, and it is never high unless a permutation was accepted 9 cycles earlier.
- R3: For an accepted permutation, output lane in_addr[3*i+:3] carries in_data[8*i+:8] for every input i; output lane j occupies out_data[8*j+:8].
- R4: Permutations accepted on consecutive cycles are routed independently, with no mixing of words between neighbouring permutations.
- R5: The identity permutation (input i addressed to lane i) passes every word straight through.
- R6: The reversing permutation (input i addressed to lane 7-i) turns the word order around.
- R7: Every steering cell leaves its pair with the smaller lane number at the lower position.
- R8: At the last steering column the sorted lane numbers equal 0,1,...,7 in position order for every accepted permutation.
- R9: Cycles with in_valid low produce cycles with out_valid low 9 cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A permutation is presented this cycle |
| in_addr | input | 24 | Eight 3-bit destination lanes, input i at bits 3*i+:3 |
| in_data | input | 64 | Eight 8-bit words, input i at bits 8*i+:8 |
| out_valid | output | 1 | Routed words are present on out_data |
| out_data | output | 64 | Eight 8-bit words, lane j at bits 8*j+:8 |

## Verification
The router is driven with the identity and reversing permutations, a one-step rotation, and a long stream of random permutations with random data, some back to back and some separated by idle cycles. Identity shows that no cell swaps without cause, while reversal forces swaps in nearly every column and exposes a wrong comparison direction or a miswired partner. Random permutations back to back reveal any skew between the swap decisions and the data they steer, since a decision applied one cycle off would take the neighbouring permutation's pattern. Idle gaps separate the valid pipeline from the data path and show that out_valid tracks in_valid with the fixed delay.

// File: rtl/pw_router_pkg.sv
package pw_router_pkg;

  // Number of compare-exchange columns for an odd-even merge sort of 2**lg inputs.
  function automatic int col_count(int lg);
    return lg * (lg + 1) / 2;
  endfunction

  // Merge block size handled by column c.
  function automatic int col_block(int lg, int c);
    int idx;
    int res;
    idx = 0;
    res = 1;
    for (int a = 0; a < lg; a++) begin
      for (int b = a; b >= 0; b--) begin
        if (idx == c) res = 1 << a;
        idx++;
      end
    end
    return res;
  endfunction

  // Comparison distance used in column c.
  function automatic int col_stride(int lg, int c);
    int idx;
    int res;
    idx = 0;
    res = 1;
    for (int a = 0; a < lg; a++) begin
      for (int b = a; b >= 0; b--) begin
        if (idx == c) res = 1 << b;
        idx++;
      end
    end
    return res;
  endfunction

  // Partner of position x in a column with block p and stride k; x itself when idle.
  function automatic int cx_partner(int n, int p, int k, int x);
    int r;
    r = x;
    for (int j = k % p; j < n - k; j += 2 * k) begin
      for (int i = 0; i < k; i++) begin
        if ((i + j) / (2 * p) == (i + j + k) / (2 * p)) begin
          if (i + j == x) r = x + k;
          else if (i + j + k == x) r = x - k;
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pw_cx_master.sv
module pw_cx_master
  import pw_router_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = 3,
  parameter int P  = 1,
  parameter int K  = 1
) (
  input  logic [N*AW-1:0] a_in,
  output logic [N*AW-1:0] a_out,
  output logic [N-1:0]    swap
);

  function automatic logic out_of_order(logic [AW-1:0] lo, logic [AW-1:0] hi);
    return lo > hi;
  endfunction

  for (genvar x = 0; x < N; x++) begin : g_pos
    localparam int PX = cx_partner(N, P, K, x);
    if (PX > x) begin : g_lo
      assign swap[x] = out_of_order(a_in[x*AW +: AW], a_in[PX*AW +: AW]);
    end else if (PX < x) begin : g_hi
      assign swap[x] = out_of_order(a_in[PX*AW +: AW], a_in[x*AW +: AW]);
    end else begin : g_idle
      assign swap[x] = 1'b0;
    end
    assign a_out[x*AW +: AW] = swap[x] ? a_in[PX*AW +: AW] : a_in[x*AW +: AW];
  end

endmodule

// File: rtl/pw_cx_slave.sv
module pw_cx_slave
  import pw_router_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8,
  parameter int P  = 1,
  parameter int K  = 1
) (
  input  logic [N*DW-1:0] d_in,
  input  logic [N-1:0]    swap,
  output logic [N*DW-1:0] d_out
);

  for (genvar x = 0; x < N; x++) begin : g_pos
    localparam int PX = cx_partner(N, P, K, x);
    assign d_out[x*DW +: DW] = swap[x] ? d_in[PX*DW +: DW] : d_in[x*DW +: DW];
  end

endmodule

// File: rtl/pw_perm_router.sv
module pw_perm_router
  import pw_router_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [N*$clog2(N)-1:0] in_addr,
  input  logic [N*DW-1:0] in_data,
  output logic            out_valid,
  output logic [N*DW-1:0] out_data
);

  localparam int AW  = $clog2(N);
  localparam int LG  = AW;
  localparam int NC  = col_count(LG);
  localparam int LAT = NC + 3;

  logic [N*AW-1:0] a_st [NC+1];
  logic [N*DW-1:0] d_st [NC+1];
  logic [N-1:0]    sw_st [NC];

  logic [N*AW-1:0] a_in_q;
  logic [N*DW-1:0] d_in_q;
  logic [N*DW-1:0] d_skew_q;
  logic [N*DW-1:0] out_q;
  logic [LAT-1:0]  v_q;

  // Named events for the checker.
  logic            sorted_valid;
  logic [N*AW-1:0] sorted_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_in_q   <= '0;
      d_in_q   <= '0;
      d_skew_q <= '0;
      out_q    <= '0;
      v_q      <= '0;
    end else begin
      a_in_q   <= in_addr;
      d_in_q   <= in_data;
      d_skew_q <= d_in_q;
      out_q    <= d_st[NC];
      v_q      <= {v_q[LAT-2:0], in_valid};
    end
  end

  assign a_st[0] = a_in_q;
  assign d_st[0] = d_skew_q;

  for (genvar c = 0; c < NC; c++) begin : g_col
    localparam int P = col_block(LG, c);
    localparam int K = col_stride(LG, c);

    logic [N*AW-1:0] a_nx;
    logic [N-1:0]    sw_nx;
    logic [N*DW-1:0] d_nx;
    logic [N*AW-1:0] a_r;
    logic [N-1:0]    sw_r;
    logic [N*DW-1:0] d_r;

    pw_cx_master #(.N(N), .AW(AW), .P(P), .K(K)) u_master (
      .a_in  (a_st[c]),
      .a_out (a_nx),
      .swap  (sw_nx)
    );

    pw_cx_slave #(.N(N), .DW(DW), .P(P), .K(K)) u_slave (
      .d_in  (d_st[c]),
      .swap  (sw_st[c]),
      .d_out (d_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_r  <= '0;
        sw_r <= '0;
        d_r  <= '0;
      end else begin
        a_r  <= a_nx;
        sw_r <= sw_nx;
        d_r  <= d_nx;
      end
    end

    assign a_st[c+1] = a_r;
    assign sw_st[c]  = sw_r;
    assign d_st[c+1] = d_r;
  end

  assign sorted_valid = v_q[NC];
  assign sorted_addr  = a_st[NC];
  assign out_valid    = v_q[LAT-1];
  assign out_data     = out_q;

endmodule

// File: rtl/pw_perm_router_chk.sv
module pw_perm_router_chk #(
  parameter int N   = 8,
  parameter int AW  = 3,
  parameter int LAT = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            out_valid,
  input logic            sorted_valid,
  input logic [N*AW-1:0] sorted_addr
);

  localparam int CW = $clog2(LAT + 1) + 1;

  logic [N*AW-1:0] ident;
  for (genvar x = 0; x < N; x++) begin : g_id
    assign ident[x*AW +: AW] = AW'(x);
  end

  logic [CW-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + CW'(in_valid) - CW'(out_valid);
  end

  // R1: reset clears the valid output.
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R2: an output only follows an accepted permutation still in flight.
  assert_out_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != '0);

  // R2: never more permutations in flight than pipeline stages.
  assert_inflight_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));

  // R8 (and R7 through it): steering network ends fully sorted.
  assert_fully_sorted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sorted_valid |-> sorted_addr == ident);

endmodule

bind pw_perm_router pw_perm_router_chk #(.N(N), .AW(AW), .LAT(LAT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .out_valid    (out_valid),
  .sorted_valid (sorted_valid),
  .sorted_addr  (sorted_addr)
);

// File: tb/pw_perm_router_test.sv
module pw_perm_router_test;

  localparam int N    = 8;
  localparam int AW   = 3;
  localparam int DW   = 8;
  localparam int DLY  = 9;
  localparam int NCYC = 400;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic [N*AW-1:0] in_addr = '0;
  logic [N*DW-1:0] in_data = '0;
  logic            out_valid;
  logic [N*DW-1:0] out_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [N*DW-1:0] exp_d [NCYC];
  bit              exp_v [NCYC];
  int              kind  [NCYC];

  always #2 clk = ~clk;

  pw_perm_router #(.N(N), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [N*DW-1:0] scatter(logic [N*AW-1:0] a, logic [N*DW-1:0] d);
    logic [N*DW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) r[int'(a[i*AW +: AW])*DW +: DW] = d[i*DW +: DW];
    return r;
  endfunction

  function automatic logic [N*AW-1:0] shuffled();
    int v [N];
    logic [N*AW-1:0] r;
    for (int i = 0; i < N; i++) v[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j;
      int t;
      j = int'($urandom % (i + 1));
      t = v[i]; v[i] = v[j]; v[j] = t;
    end
    for (int i = 0; i < N; i++) r[i*AW +: AW] = AW'(v[i]);
    return r;
  endfunction

  function automatic string tag(int k);
    case (k)
      5: return "R5";
      6: return "R6";
      4: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check_cycle(int t);
    checks++;
    if (out_valid !== exp_v[t]) begin
      errors++;
      $display("FAIL %s: out_valid for slot %0d actual=%0b expected=%0b",
               exp_v[t] ? "R2" : "R9", t, out_valid, exp_v[t]);
    end
    if (exp_v[t]) begin
      checks++;
      if (out_data !== exp_d[t]) begin
        errors++;
        $display("FAIL %s: slot %0d out_data actual=%h expected=%h",
                 tag(kind[t]), t, out_data, exp_d[t]);
      end
    end
  endtask

  initial begin
    logic [N*AW-1:0] a;
    logic [N*DW-1:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1: in reset actual=%0b/%h expected=0/0", out_valid, out_data);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R1: after reset actual=%0b/%h expected=0/0", out_valid, out_data);
    end
    for (int t = 0; t < NCYC + DLY; t++) begin
      if (t >= DLY) check_cycle(t - DLY);
      if (t < NCYC) begin
        for (int i = 0; i < N; i++) d[i*DW +: DW] = DW'($urandom);
        kind[t] = 3;
        if (t == 0) begin
          for (int i = 0; i < N; i++) a[i*AW +: AW] = AW'(i);
          kind[t] = 5;
          exp_v[t] = 1;
        end else if (t == 1) begin
          for (int i = 0; i < N; i++) a[i*AW +: AW] = AW'(N - 1 - i);
          kind[t] = 6;
          exp_v[t] = 1;
        end else if (t == 2) begin
          for (int i = 0; i < N; i++) a[i*AW +: AW] = AW'((i + 1) % N);
          exp_v[t] = 1;
        end else if (t == 3 || (t >= 200 && t < 215)) begin
          a = shuffled();
          exp_v[t] = 0;
        end else begin
          a = shuffled();
          exp_v[t] = ($urandom % 5) != 0;
          if (exp_v[t] && exp_v[t-1]) kind[t] = 4;
        end
        exp_d[t] = scatter(a, d);
        in_addr  = a;
        in_data  = d;
        in_valid = exp_v[t];
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule